// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. A decimal counter of `DIGITS` BCD digits (four by default, so 0000 to 9999) sets the length of a fixed integration phase and then measures a variable de-integration phase. The analog integrator, the input switch and the zero-crossing comparator sit outside the block. The sequencer drives the switch select and reads the comparator bit.

A conversion begins with a start pulse. The counter is cleared, the integrator is fed from the unknown input, and the counter advances once per clock. When the counter wraps past all nines, that carry out of the top digit moves the select to the negative reference. The counter then starts again from zero and runs until the comparator reports that the integrator charge has reached zero. The count at that moment is frozen and latched as the BCD result. Because the charge phase is fixed and the discharge phase is measured, the result is proportional to the input divided by the reference. If the discharge count reaches all nines again without a trip, the conversion stops and is flagged as out of range.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset the block is idle: busy, select, done and overrange are low, and both the live count and the result read zero.
- R2: A start pulse while idle clears the count to zero. From the next cycle on, busy is high and select is low, so the integrator is fed from the input.
- R3: Each 4-bit field of the count is a BCD digit (digit k at bits 4k+3..4k, least significant digit at bits 3..0) that never exceeds 9. The count goes up by exactly one decimal step per clock, and a digit that rolls from 9 to 0 carries into the next digit.
- R4: The run-up lasts exactly 10^DIGITS cycles, counted from the cycle busy rises. On the rollover from all nines to all zeros, select goes high with the count at zero.
- R5: During run-down the count advances once per cycle from zero. In the cycle where the comparator input is high, the count is frozen and latched into the result. The result therefore equals the number of run-down cycles completed before the trip, which with the integrator model is ceil(input·10^DIGITS / reference).
- R6: Completion is marked by a single-cycle done pulse. Busy and select fall in the same cycle as done rises.
- R7: If the run-down count stands at all nines and the comparator has not tripped, the conversion ends. The result is all nines and overrange goes high, staying high until the next start.
- R8: A start pulse while busy has no effect on the count, the phase or the outputs.
- R9: The comparator input is ignored outside the run-down phase.
- R10: The result holds its value between completions and changes only in a cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion (accepted only while idle) |
| cmp_zero_i | input | 1 | Comparator: integrator charge has returned to zero |
| sel_ref_o | output | 1 | 0 = integrator fed from input, 1 = fed from negative reference |
| busy_o | output | 1 | High from start until the result is latched |
| done_o | output | 1 | One-cycle completion pulse |
| ovr_o | output | 1 | Out-of-range flag for the last conversion |
| count_o | output | 4*DIGITS | Live BCD counter value |
| result_o | output | 4*DIGITS | Latched BCD result |

## Verification
The hardest states to reach are the two edges of the measurement window: a trip in the very first run-down cycle (zero input), and the overrange stop, where the count sits at all nines with the comparator still low. Both need a full 10^DIGITS-cycle run-up first. The bench reaches them with a behavioural charge integrator: zero input, an input just below the reference and an input exactly equal to it. Start pulses repeated while busy, and comparator pulses injected during run-up, are laid over some of those conversions so that the ignore cases are observed at the count and select outputs.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUNUP = 2'd1,
        PH_RUNDN = 2'd2
    } phase_e;

    localparam int unsigned BCD_W = 4;
    localparam logic [3:0] BCD_MAX = 4'd9;
endpackage

// File: rtl/dsadc_bcd_digit.sv
module dsadc_bcd_digit
    import dsadc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [BCD_W-1:0] digit_o,
    output logic             carry_o
);
    logic [BCD_W-1:0] digit_d, digit_q;

    always_comb begin
        digit_d = digit_q;
        if (clr_i) begin
            digit_d = '0;
        end else if (inc_i) begin
            digit_d = (digit_q == BCD_MAX) ? '0 : digit_q + 4'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) digit_q <= '0;
        else        digit_q <= digit_d;
    end

    assign digit_o = digit_q;
    assign carry_o = inc_i && !clr_i && (digit_q == BCD_MAX);

    assert_digit_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        digit_q <= BCD_MAX);

    assert_digit_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> (digit_q == '0));
endmodule

// File: rtl/dsadc_bcd_counter.sv
module dsadc_bcd_counter
    import dsadc_pkg::*;
#(
    parameter int unsigned DIGITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     inc_i,
    output logic [DIGITS*BCD_W-1:0]  count_o,
    output logic                     ovf_o,
    output logic                     all_nines_o
);
    localparam int unsigned CW = DIGITS * BCD_W;

    logic [DIGITS:0]   inc_chain;
    logic [DIGITS-1:0] carry;
    logic [DIGITS-1:0] is_nine;

    assign inc_chain[0] = inc_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        dsadc_bcd_digit u_digit (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr_i),
            .inc_i   (inc_chain[g]),
            .digit_o (count_o[g*BCD_W +: BCD_W]),
            .carry_o (carry[g])
        );
        assign inc_chain[g+1] = carry[g];
        assign is_nine[g]     = (count_o[g*BCD_W +: BCD_W] == BCD_MAX);
    end

    assign all_nines_o = &is_nine;
    assign ovf_o       = inc_chain[DIGITS];

    assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (count_o == {CW{1'b0}}));
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
    import dsadc_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          cmp_zero_i,
    input  logic          ovf_i,
    input  logic          all_nines_i,
    input  logic [CW-1:0] count_i,
    output logic          clr_o,
    output logic          inc_o,
    output logic          sel_ref_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          ovr_o,
    output logic [CW-1:0] result_o
);
    typedef struct packed {
        phase_e        phase;
        logic          done;
        logic          ovr;
        logic [CW-1:0] result;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        clr_o     = 1'b0;
        inc_o     = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    clr_o      = 1'b1;
                    st_d.phase = PH_RUNUP;
                    st_d.ovr   = 1'b0;
                end
            end
            PH_RUNUP: begin
                inc_o = 1'b1;
                if (ovf_i) st_d.phase = PH_RUNDN;
            end
            PH_RUNDN: begin
                if (cmp_zero_i) begin
                    st_d.result = count_i;
                    st_d.done   = 1'b1;
                    st_d.phase  = PH_IDLE;
                end else if (all_nines_i) begin
                    st_d.result = count_i;
                    st_d.ovr    = 1'b1;
                    st_d.done   = 1'b1;
                    st_d.phase  = PH_IDLE;
                end else begin
                    inc_o = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, done: 1'b0, ovr: 1'b0, result: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = (st_q.phase != PH_IDLE);
    assign sel_ref_o = (st_q.phase == PH_RUNDN);
    assign done_o    = st_q.done;
    assign ovr_o     = st_q.ovr;
    assign result_o  = st_q.result;

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_sel_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ref_o |-> busy_o);

    assert_sel_rise_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ref_o) |-> (count_i == '0));

    assert_ovr_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> done_o);

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || $stable(result_o)));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !sel_ref_o && count_i == '0));
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
    import dsadc_pkg::*;
#(
    parameter int unsigned DIGITS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    cmp_zero_i,
    output logic                    sel_ref_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    ovr_o,
    output logic [DIGITS*BCD_W-1:0] count_o,
    output logic [DIGITS*BCD_W-1:0] result_o
);
    localparam int unsigned CW = DIGITS * BCD_W;

    logic          cnt_clr;
    logic          cnt_inc;
    logic          cnt_ovf;
    logic          cnt_nines;
    logic [CW-1:0] cnt_val;

    dsadc_bcd_counter #(.DIGITS(DIGITS)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (cnt_clr),
        .inc_i       (cnt_inc),
        .count_o     (cnt_val),
        .ovf_o       (cnt_ovf),
        .all_nines_o (cnt_nines)
    );

    dsadc_ctrl #(.CW(CW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cmp_zero_i  (cmp_zero_i),
        .ovf_i       (cnt_ovf),
        .all_nines_i (cnt_nines),
        .count_i     (cnt_val),
        .clr_o       (cnt_clr),
        .inc_o       (cnt_inc),
        .sel_ref_o   (sel_ref_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .ovr_o       (ovr_o),
        .result_o    (result_o)
    );

    assign count_o = cnt_val;

    assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(count_o));
endmodule

// File: tb/dual_slope_seq_tb_top.sv
module dual_slope_seq_tb_top;
    localparam int DIGITS = 4;
    localparam int CW     = DIGITS * 4;
    localparam int SPAN   = 10 ** DIGITS;
    localparam int LAST   = SPAN - 1;
    localparam int VREF   = 1000;
    localparam int WDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          cmp_zero_i = 1'b0;
    logic          sel_ref_o, busy_o, done_o, ovr_o;
    logic [CW-1:0] count_o, result_o;

    always #5 clk = ~clk;

    dual_slope_seq #(.DIGITS(DIGITS)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmp_zero_i (cmp_zero_i),
        .sel_ref_o  (sel_ref_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .ovr_o      (ovr_o),
        .count_o    (count_o),
        .result_o   (result_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // reference model state (0 idle, 1 run-up, 2 run-down)
    int m_phase = 0;
    int m_cnt   = 0;
    int m_res   = 0;
    bit m_done  = 0;
    bit m_ovr   = 0;
    int charge  = 0;
    int vin     = 0;
    bit noise   = 0;
    bit spam    = 0;
    int busy_cyc = 0;
    int runup_len = 0;

    function automatic logic [CW-1:0] to_bcd(int v);
        logic [CW-1:0] r = '0;
        int x = v;
        for (int k = 0; k < DIGITS; k++) begin
            r[k*4 +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // one clock: compare, drive inputs, advance model
    task automatic tick(bit want_start);
        bit s, c;
        @(negedge clk);
        cyc++;
        if (cyc > WDOG) begin
            checks++; fails++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cyc);
            finish_run();
        end
        chk("R3 count", 32'(count_o), 32'(to_bcd(m_cnt)));
        chk("R2 busy", 32'(busy_o), 32'(m_phase != 0));
        chk("R4 select", 32'(sel_ref_o), 32'(m_phase == 2));
        chk("R6 done", 32'(done_o), 32'(m_done));
        chk("R7 overrange", 32'(ovr_o), 32'(m_ovr));
        chk("R10 result", 32'(result_o), 32'(to_bcd(m_res)));
        if (busy_o) busy_cyc++;
        if (busy_o && !sel_ref_o) runup_len++;
        // inputs: R8 spam starts while busy, R9 comparator noise out of run-down
        s = want_start || (spam && m_phase != 0 && (cyc % 5 == 0));
        c = (m_phase == 2) ? (charge <= 0) : (noise && (cyc % 7 == 0));
        start_i    = s;
        cmp_zero_i = c;
        // model step
        m_done = 0;
        case (m_phase)
            0: if (s) begin m_phase = 1; m_cnt = 0; m_ovr = 0; charge = 0; end
            1: begin
                charge += vin;
                if (m_cnt == LAST) begin m_cnt = 0; m_phase = 2; end
                else m_cnt++;
            end
            default: begin
                if (c) begin
                    m_res = m_cnt; m_done = 1; m_phase = 0;
                end else if (m_cnt == LAST) begin
                    m_res = m_cnt; m_ovr = 1; m_done = 1; m_phase = 0;
                end else begin
                    charge -= VREF; m_cnt++;
                end
            end
        endcase
    endtask

    task automatic convert(int v, bit nz, bit sp);
        int exp_res;
        bit exp_ovr;
        vin = v; noise = nz; spam = sp;
        runup_len = 0;
        tick(1'b1);
        while (m_phase != 0) tick(1'b0);
        tick(1'b0);   // observe the done cycle
        spam = 0; noise = 0;
        exp_res = (v * SPAN + VREF - 1) / VREF;
        exp_ovr = (exp_res > LAST);
        if (exp_ovr) exp_res = LAST;
        chk("R5 proportional result", 32'(result_o), 32'(to_bcd(exp_res)));
        chk("R7 overrange flag", 32'(ovr_o), 32'(exp_ovr));
        chk("R4 run-up length", 32'(runup_len), 32'(SPAN));
        for (int i = 0; i < 3; i++) tick(1'b0);
        chk("R10 result held", 32'(result_o), 32'(to_bcd(exp_res)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 select", 32'(sel_ref_o), 32'd0);
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 overrange", 32'(ovr_o), 32'd0);
        chk("R1 count", 32'(count_o), 32'd0);
        chk("R1 result", 32'(result_o), 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) tick(1'b0);
        convert(0, 1'b0, 1'b0);      // R5 trip in first run-down cycle
        convert(1, 1'b1, 1'b0);      // R9 comparator noise in run-up
        convert(333, 1'b1, 1'b1);    // R8 start while busy, R3 carries
        convert(999, 1'b0, 1'b0);    // just inside range
        convert(1000, 1'b0, 1'b1);   // R7 overrange at exact reference
        convert(500, 1'b0, 1'b0);    // R7 flag cleared by next start
        finish_run();
    end
endmodule